// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator Run Control and Event Collector

This block is the shared control layer that sits in front of four pulse-width channel datapaths. It decodes a simple strobe-driven register bus into a small set of global registers (set-run, request-stop, run status, update-event status) and into one address window per channel, which it forwards to the channel instance as one-hot strobes plus an in-window offset. The channel datapaths stay outside: each supplies a period-boundary pulse and an update-event pulse, and accepts a run-enable level from this block.

A stop request does not cut a channel off at once. The channel keeps running until its current period ends, and only then does its run-enable and its status bit fall. Software that wants to gate the channel clock must therefore poll the status bit. Update events from all channels collect in a sticky status register. A read of that register returns the collected set and clears it in the same access, and the interrupt output is raised whenever any collected bit is set.

The bus is plain control: single-cycle write and read strobes with no back-pressure. Read data comes back with a one-cycle valid pulse in the cycle after the read strobe, and the requester must take it in that cycle.

Top module: `pwm_run_hub`

## Requirements
- R1: After reset every run-enable, every status bit, the event status, the interrupt and the read-valid output are all 0.
- R2: A write to offset 0x04 sets run-enable k for each bit k of the written data that is 1, effective in the cycle after the strobe. Bits written as 0 leave their channel unchanged.
- R3: A write to offset 0x08 marks each running channel whose data bit is 1 as stopping. That channel keeps its run-enable and status bit until a period-boundary pulse arrives from it in a later cycle, and both fall in the cycle after that pulse. Bits written as 0, and boundary pulses from a channel that is not stopping, change nothing.
- R4: A write to offset 0x04 with bit k set cancels a pending stop on channel k, so it stays running past later boundary pulses.
- R5: A read of offset 0x0C returns the run state of channel k in bit k and zero in all higher bits. With all four channels running, it reads 0x0000000F.
- R6: Update-event pulses set the matching bit of the event status. A read of offset 0x1C returns the collected bits and clears them.
- R7: An update event that arrives in the same cycle as a read of offset 0x1C is not in that read's data but appears in the next read.
- R8: The interrupt output is 1 exactly when at least one event status bit is set, so it rises in the cycle after an event and falls in the cycle after a clearing read that sees no new event.
- R9: An access to address 0x200 + k*0x20 + off, with off below 0x20 and k below 4, raises only channel strobe k (write or read) in the same cycle and drives the channel offset output with off. The read returns that channel's 32-bit read data.
- R10: Read data is valid, with the read-valid output high, for one cycle in the cycle after the read strobe. Reads of unmapped addresses and of offsets 0x04 and 0x08 return 0, and accesses outside the channel windows raise no channel strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data; also the write data seen by the channels |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle in the cycle after a read strobe |
| ch_wr | output | 4 | One-hot write strobe to the addressed channel |
| ch_rd | output | 4 | One-hot read strobe to the addressed channel |
| ch_off | output | 5 | Byte offset inside the channel window |
| ch_rdata | input | 128 | Read data of each channel, channel k in bits 32k+31..32k |
| period_end | input | 4 | Period-boundary pulse per channel |
| upd_evt | input | 4 | Update-event pulse per channel |
| run_en | output | 4 | Run enable per channel |
| irq | output | 1 | Any event status bit set |

## Verification
The run logic is swept over all sixteen enable masks and all sixteen stop masks from a fully running state. Reading status both before and after a boundary pulse shows whether a stop is deferred, and the same reads show that zero bits leave other channels alone. The event register is swept over all sixteen event patterns, each followed by two reads, which separates accumulation from clearing. One read is made with a new event in the same cycle, which tells a design that keeps the late event from one that loses it or leaks it into the current data. Every channel window is visited at several offsets and checked against an address just past the last window, which tells correct index and offset decoding from an off-by-one window boundary.

// File: rtl/pwm_run_hub_pkg.sv
package pwm_run_hub_pkg;

  localparam int OFS_RUN_SET  = 'h004;
  localparam int OFS_RUN_STOP = 'h008;
  localparam int OFS_RUN_STAT = 'h00C;
  localparam int OFS_EVT_STAT = 'h01C;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SET,
    TGT_STOP,
    TGT_STAT,
    TGT_EVT,
    TGT_CHAN
  } tgt_e;

endpackage

// File: rtl/pwm_hub_decode.sv
module pwm_hub_decode
  import pwm_run_hub_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NCH       = 4,
  parameter int CH_BASE   = 'h200,
  parameter int CH_STRIDE = 'h20,
  localparam int OFF_W    = $clog2(CH_STRIDE),
  localparam int IDX_W    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic [NCH-1:0]    sel_wr,
  output logic [NCH-1:0]    sel_rd,
  output logic [OFF_W-1:0]  off
);

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(CH_BASE + NCH * CH_STRIDE);

  logic [ADDR_W-1:0] rel;
  logic              in_win;

  assign rel    = addr - WIN_LO;
  assign in_win = (addr >= WIN_LO) && (addr < WIN_HI);
  assign idx    = rel[OFF_W +: IDX_W];
  assign off    = addr[OFF_W-1:0];

  always_comb begin
    tgt = TGT_NONE;
    if (in_win)                               tgt = TGT_CHAN;
    else if (addr == ADDR_W'(OFS_RUN_SET))    tgt = TGT_SET;
    else if (addr == ADDR_W'(OFS_RUN_STOP))   tgt = TGT_STOP;
    else if (addr == ADDR_W'(OFS_RUN_STAT))   tgt = TGT_STAT;
    else if (addr == ADDR_W'(OFS_EVT_STAT))   tgt = TGT_EVT;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_sel
    assign sel_wr[k] = wr && in_win && (idx == IDX_W'(k));
    assign sel_rd[k] = rd && in_win && (idx == IDX_W'(k));
  end

  // R9: at most one channel strobe of each kind per cycle
  p_onehot_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_wr) && $onehot0(sel_rd));

  // R10: no channel strobe without a bus strobe
  p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !rd) |-> (sel_wr == '0 && sel_rd == '0));

endmodule

// File: rtl/pwm_hub_runctl.sv
module pwm_hub_runctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_req,
  input  logic [NCH-1:0] stop_req,
  input  logic [NCH-1:0] period_end,
  output logic [NCH-1:0] run
);

  logic [NCH-1:0] stopping;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run[k]      <= 1'b0;
        stopping[k] <= 1'b0;
      end else if (stop_req[k]) begin
        // stop wins over a coincident set; a stopped channel stays stopped
        if (run[k] || set_req[k]) stopping[k] <= 1'b1;
        if (set_req[k])           run[k]      <= 1'b1;
      end else if (set_req[k]) begin
        run[k]      <= 1'b1;
        stopping[k] <= 1'b0;
      end else if (stopping[k] && period_end[k]) begin
        run[k]      <= 1'b0;
        stopping[k] <= 1'b0;
      end
    end

    // R3: a channel only stops at a boundary while a stop is pending
    p_stop_at_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run[k]) |-> $past(stopping[k] && period_end[k]));

    // R3: a pending stop without a boundary keeps the channel running
    p_hold_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stopping[k] && !period_end[k] && !set_req[k]) |=> run[k]);

    // R2: a channel only starts after a set request
    p_start_by_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[k]) |-> $past(set_req[k]));

    // R4: a set without stop cancels a pending stop
    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req[k] && !stop_req[k]) |=> (run[k] && !stopping[k]));
  end

endmodule

// File: rtl/pwm_hub_evtacc.sv
module pwm_hub_evtacc #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           rd_clr,
  output logic [NCH-1:0] pend
);

  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= '0;
    else if (rd_clr) pend <= evt;
    else             pend <= pend | evt;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R7: an event is never lost, even during a clearing read
    p_evt_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> pend[k]);

    // R6: a clearing read with no new event empties the bit
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !evt[k]) |=> !pend[k]);

    // R6: without a read a collected bit stays set
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[k] && !rd_clr) |=> pend[k]);
  end

endmodule

// File: rtl/pwm_run_hub.sv
module pwm_run_hub
  import pwm_run_hub_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DW        = 32,
  parameter int NCH       = 4,
  parameter int CH_BASE   = 'h200,
  parameter int CH_STRIDE = 'h20,
  localparam int OFF_W    = $clog2(CH_STRIDE),
  localparam int IDX_W    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic [NCH-1:0]    ch_wr,
  output logic [NCH-1:0]    ch_rd,
  output logic [OFF_W-1:0]  ch_off,
  input  logic [NCH*DW-1:0] ch_rdata,
  input  logic [NCH-1:0]    period_end,
  input  logic [NCH-1:0]    upd_evt,
  output logic [NCH-1:0]    run_en,
  output logic              irq
);

  tgt_e             tgt;
  logic [IDX_W-1:0] idx;
  logic [NCH-1:0]   set_req;
  logic [NCH-1:0]   stop_req;
  logic [NCH-1:0]   evt_pend;
  logic             evt_clr;

  pwm_hub_decode #(
    .ADDR_W(ADDR_W), .NCH(NCH), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .tgt(tgt), .idx(idx), .sel_wr(ch_wr), .sel_rd(ch_rd), .off(ch_off)
  );

  assign set_req  = (bus_wr && tgt == TGT_SET)  ? bus_wdata[NCH-1:0] : '0;
  assign stop_req = (bus_wr && tgt == TGT_STOP) ? bus_wdata[NCH-1:0] : '0;
  assign evt_clr  = bus_rd && (tgt == TGT_EVT);

  pwm_hub_runctl #(.NCH(NCH)) u_run (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .stop_req(stop_req),
    .period_end(period_end), .run(run_en)
  );

  pwm_hub_evtacc #(.NCH(NCH)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt(upd_evt), .rd_clr(evt_clr), .pend(evt_pend)
  );

  assign irq = |evt_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (tgt)
          TGT_STAT: bus_rdata <= DW'(run_en);
          TGT_EVT:  bus_rdata <= DW'(evt_pend);
          TGT_CHAN: bus_rdata <= ch_rdata[idx*DW +: DW];
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  // R10: every read strobe is answered in the next cycle
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R8: any event raises the interrupt in the next cycle
  p_irq_after_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_evt) |=> irq);

  // R5: a status read reports the run state sampled at the strobe
  p_stat_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && tgt == TGT_STAT) |=> (bus_rdata == DW'($past(run_en))));

endmodule

// File: tb/pwm_run_hub_test.sv
`timescale 1ns/1ps
module pwm_run_hub_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [3:0]   ch_wr, ch_rd;
  logic [4:0]   ch_off;
  logic [127:0] ch_rdata;
  logic [3:0]   period_end = '0, upd_evt = '0;
  logic [3:0]   run_en;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] chan_val(int k);
    return 32'hC4A0_0000 + 32'(k) * 32'h0000_1111;
  endfunction

  always_comb
    for (int k = 0; k < 4; k++) ch_rdata[k*32 +: 32] = chan_val(k);

  pwm_run_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_off(ch_off),
    .ch_rdata(ch_rdata), .period_end(period_end), .upd_evt(upd_evt),
    .run_en(run_en), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // returns read data sampled in the cycle after the strobe
  task automatic rd(logic [11:0] a, logic [3:0] evt, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; upd_evt = evt;
    @(negedge clk);
    bus_rd = 1'b0; upd_evt = '0;
    chk("R10 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic pulse_end(logic [3:0] m);
    @(negedge clk); period_end = m;
    @(negedge clk); period_end = '0;
  endtask

  task automatic pulse_evt(logic [3:0] m);
    @(negedge clk); upd_evt = m;
    @(negedge clk); upd_evt = '0;
  endtask

  task automatic stop_all();
    wr(12'h008, 32'hF);
    pulse_end(4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 run_en", 32'(run_en), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rvalid", 32'(bus_rvalid), 32'h0);
    rd(12'h00C, 4'h0, d); chk("R1 status", d, 32'h0);
    rd(12'h01C, 4'h0, d); chk("R1 evt", d, 32'h0);

    // R2 sweep of enable masks; zero bits leave others stopped
    for (int m = 0; m < 16; m++) begin
      wr(12'h004, 32'(m));
      chk("R2 run_en", 32'(run_en), 32'(m));
      wr(12'h004, 32'h0);
      rd(12'h00C, 4'h0, d); chk("R2 status after zero write", d, 32'(m));
      stop_all();
      chk("R3 all stopped", 32'(run_en), 32'h0);
    end

    // R5 all running reads 0xF
    wr(12'h004, 32'hF);
    rd(12'h00C, 4'h0, d); chk("R5 all on", d, 32'h0000_000F);

    // R3 sweep of stop masks: deferred until boundary
    for (int m = 0; m < 16; m++) begin
      wr(12'h004, 32'hF);
      pulse_end(4'hF);
      chk("R3 boundary without stop", 32'(run_en), 32'hF);
      wr(12'h008, 32'(m));
      rd(12'h00C, 4'h0, d); chk("R3 still running before boundary", d, 32'hF);
      pulse_end(4'hF);
      rd(12'h00C, 4'h0, d); chk("R3 stopped after boundary", d, 32'(~m & 4'hF));
    end

    // R3 boundary only on other channels does not stop channel 0
    wr(12'h004, 32'hF);
    wr(12'h008, 32'h1);
    pulse_end(4'hE);
    chk("R3 other boundary", 32'(run_en), 32'hF);
    pulse_end(4'h1);
    chk("R3 own boundary", 32'(run_en), 32'hE);

    // R4 cancel pending stop
    wr(12'h004, 32'hF);
    wr(12'h008, 32'hF);
    wr(12'h004, 32'h5);
    pulse_end(4'hF);
    chk("R4 cancelled stop", 32'(run_en), 32'h5);
    stop_all();

    // R6/R8 sweep of event patterns
    for (int e = 0; e < 16; e++) begin
      pulse_evt(4'(e));
      chk("R8 irq after event", 32'(irq), 32'(e != 0));
      rd(12'h01C, 4'h0, d); chk("R6 collected", d, 32'(e));
      chk("R8 irq after clear", 32'(irq), 32'h0);
      rd(12'h01C, 4'h0, d); chk("R6 cleared", d, 32'h0);
    end

    // R6 accumulation across pulses
    pulse_evt(4'h1);
    pulse_evt(4'h8);
    rd(12'h01C, 4'h0, d); chk("R6 accumulate", d, 32'h9);

    // R7 event in same cycle as clearing read
    pulse_evt(4'h3);
    rd(12'h01C, 4'hC, d); chk("R7 read excludes late event", d, 32'h3);
    chk("R8 irq held by late event", 32'(irq), 32'h1);
    rd(12'h01C, 4'h0, d); chk("R7 late event kept", d, 32'hC);

    // R9 channel windows
    for (int k = 0; k < 4; k++) begin
      for (int o = 0; o < 32; o += 12) begin
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'(32'h200 + k * 32'h20 + o);
        #1;
        chk("R9 ch_wr", 32'(ch_wr), 32'(1 << k));
        chk("R9 ch_off", 32'(ch_off), 32'(o));
        chk("R9 ch_rd idle", 32'(ch_rd), 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b1;
        #1;
        chk("R9 ch_rd", 32'(ch_rd), 32'(1 << k));
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 read data", bus_rdata, chan_val(k));
      end
    end

    // R10 unmapped and write-only offsets
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h280;
    #1 chk("R10 no strobe past windows", 32'(ch_wr), 32'h0);
    @(negedge clk); bus_wr = 1'b0;
    rd(12'h280, 4'h0, d); chk("R10 unmapped past windows", d, 32'h0);
    rd(12'h1FC, 4'h0, d); chk("R10 unmapped before windows", d, 32'h0);
    wr(12'h004, 32'h6);
    rd(12'h004, 4'h0, d); chk("R10 set offset reads 0", d, 32'h0);
    rd(12'h008, 4'h0, d); chk("R10 stop offset reads 0", d, 32'h0);
    @(negedge clk);
    chk("R10 rvalid one cycle", 32'(bus_rvalid), 32'h0);
    chk("R10 unmapped write no effect", 32'(run_en), 32'h6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule